// File: doc/BRIEF.md
# External Interrupt Controller Core

This block gathers up to 64 interrupt lines from around the chip and presents one request at a time to a processor core. Each line is synchronised and turned into a pending flag, either by following its level or by catching an edge. Flags that are enabled by a per-channel mask compete in a tree-shaped priority encoder, and the highest-numbered pending channel wins. The winner is sent to the processor as an 8-bit requested level together with either a 6-bit vector number or a handler offset, depending on a build-time mode.

Software reaches the controller through a simple valid/write/address/data register port. It can set and clear edge flags, program masks, choose the sense mode of the lower channels and turn on automatic clearing. When the processor starts servicing a request, it returns a one-cycle acknowledge carrying the level, vector and offset it took. If automatic clearing is on, the controller then drops the matching edge flag by itself.

Top module: `eic_core`

## Requirements
- R1: After reset the request outputs are zero, the controller-present output is high, flags, masks and the control word read as zero, and every sense-configurable channel is in rising-edge mode (both sense words read 0x55555555).
- R2: Reading address 0 returns flags of channels 0..31 and address 1 returns channels 32..63, with channel n at bit n mod 32; a set bit means channel n is pending.
- R3: Channels below NUM_SENSE take a 2-bit sense code, with channel c at bits [2(c mod 16)+1 : 2(c mod 16)] of address 8 (c < 16) or address 9: 0 is low level, 1 rising edge, 2 falling edge, 3 any edge. An edge sets the flag, and the flag stays set after the input returns.
- R4: Channels at or above NUM_SENSE are always active-high level sensed. Their flag follows the input, and writes to the set and clear addresses do not affect them.
- R5: A level-sensed flag follows its synchronised input. Software set and clear writes and acknowledge clears have no lasting effect on it.
- R6: Writing a one to bit n mod 32 of address 2/3 sets edge flag n, and writing a one to address 4/5 clears it. Zero bits leave the flag unchanged.
- R7: Address 6/7 holds the mask, where bit n = 1 lets channel n compete. Among pending enabled channels, the highest channel number wins.
- R8: The requested level is n+1 for winning channel n and 0 when nothing competes. In that idle case the vector and offset are also 0.
- R9: With OFFSET_MODE=1 the offset output (bits 17:1) carries (0x200 + n*0x20) >> 1 and the vector is 0. With OFFSET_MODE=0 the vector carries n and the offset is 0. Channel 63 maps to byte offset 0x9E0.
- R10: When bit 0 of address 10 is 1, an acknowledge pulse clears edge flag n. The channel n is decoded from the vector (vector mode) or the offset (offset mode), and the acknowledged level must equal n+1. When bit 0 is 0, an acknowledge changes no flag.
- R11: An input change is caught by a two-flop synchroniser and takes effect on the outputs on the fourth clock edge after it is applied. The request outputs are registered one cycle after the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_CH | Interrupt source lines |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |
| req_level | output | 8 | Requested level (0 = none) |
| req_vector | output | 6 | Requested vector number |
| req_offset | output | 17 | Requested handler offset, bits 17:1 |
| ctrl_present | output | 1 | Controller present, tied high |
| ack_pulse | input | 1 | One-cycle service acknowledge |
| ack_level | input | 8 | Level being serviced |
| ack_vector | input | 6 | Vector being serviced |
| ack_offset | input | 17 | Offset being serviced, bits 17:1 |

## Verification
The selection path is driven with a single pending channel, with two competing channels, and with a competing channel masked off, which separates winner choice by channel number from mask handling. Each sense code is tried with both input directions: a rising input must not set a falling-edge flag, any-edge must latch on both transitions, and low level must track the input. Level channels receive set, clear and acknowledge stimulus while their input stays active, and edge channels receive acknowledges with auto-clear both off and on, so a flag that is cleared wrongly or kept wrongly shows at the outputs. Channel 63 and a sample at the exact latency cycle pin down the encoding and the pipeline depth.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int REG_W = 32;
  localparam int VEC_W = 6;
  localparam int LVL_W = 8;
  localparam int OFS_W = 17;
  localparam int ADDR_W = 4;
  localparam int VEC_BASE = 'h200;
  localparam int VEC_STEP = 'h20;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'd0,
    SENSE_RISE = 2'd1,
    SENSE_FALL = 2'd2,
    SENSE_ANY  = 2'd3
  } sense_e;

  localparam logic [ADDR_W-1:0] A_FLAG  = 4'd0;
  localparam logic [ADDR_W-1:0] A_SET   = 4'd2;
  localparam logic [ADDR_W-1:0] A_CLR   = 4'd4;
  localparam logic [ADDR_W-1:0] A_MASK  = 4'd6;
  localparam logic [ADDR_W-1:0] A_SENSE = 4'd8;
  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd10;
endpackage

// File: rtl/eic_channel.sv
module eic_channel
  import eic_pkg::*;
#(
  parameter bit CONFIGURABLE = 1'b1
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   din,
  input  sense_e mode,
  input  logic   sw_set,
  input  logic   clr,
  output logic   flag,
  output logic   is_edge,
  output logic   evt
);
  logic s1_q, s2_q, prev_q, flag_q;
  logic lvl_c;
  logic rise_c, fall_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= din;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rise_c = s2_q & ~prev_q;
  assign fall_c = ~s2_q & prev_q;

  generate
    if (CONFIGURABLE) begin : g_cfg
      always_comb begin
        is_edge = 1'b1;
        evt     = 1'b0;
        lvl_c   = 1'b0;
        unique case (mode)
          SENSE_LOW:  begin is_edge = 1'b0; lvl_c = ~s2_q; end
          SENSE_RISE: evt = rise_c;
          SENSE_FALL: evt = fall_c;
          default:    evt = rise_c | fall_c;
        endcase
      end
    end else begin : g_fixed
      logic mode_unused;
      assign mode_unused = ^mode;
      assign is_edge = 1'b0;
      assign evt     = 1'b0;
      assign lvl_c   = s2_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (is_edge) flag_q <= (flag_q & ~clr) | evt | sw_set;
    else              flag_q <= lvl_c;
  end

  assign flag = flag_q;
endmodule

// File: rtl/eic_prio_tree.sv
module eic_prio_tree #(
  parameter int N  = 64,
  parameter int IW = 6
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  localparam int LV = (N > 1) ? $clog2(N) : 0;
  localparam int NP = 1 << LV;

  logic [NP-1:0] v;
  logic [IW-1:0] ix [NP];

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      v[i]  = (i < N) ? req[i] : 1'b0;
      ix[i] = IW'(i);
    end
    for (int l = 0; l < LV; l++) begin
      for (int j = 0; j < NP / 2; j++) begin
        if (j < (NP >> (l + 1))) begin
          ix[j] = v[2*j+1] ? ix[2*j+1] : ix[2*j];
          v[j]  = v[2*j+1] | v[2*j];
        end
      end
    end
    any = v[0];
    idx = ix[0];
  end
endmodule

// File: rtl/eic_map.sv
module eic_map
  import eic_pkg::*;
#(
  parameter int NUM_CH      = 64,
  parameter int OFFSET_MODE = 1
) (
  input  logic             win_any,
  input  logic [VEC_W-1:0] win_idx,
  output logic [LVL_W-1:0] out_level,
  output logic [VEC_W-1:0] out_vector,
  output logic [OFS_W-1:0] out_offset,
  input  logic [LVL_W-1:0] ack_level,
  input  logic [VEC_W-1:0] ack_vector,
  input  logic [OFS_W-1:0] ack_offset,
  output logic [VEC_W-1:0] ack_idx,
  output logic             ack_ok
);
  localparam int HALF_BASE = VEC_BASE / 2;
  localparam int HALF_STEP = VEC_STEP / 2;
  localparam int STEP_SH   = $clog2(HALF_STEP);

  logic [OFS_W-1:0] rel;
  logic [VEC_W-1:0] idx_o;
  logic             fit_o;

  assign out_level = win_any ? LVL_W'(int'(win_idx) + 1) : '0;

  generate
    if (OFFSET_MODE != 0) begin : g_ofs
      assign out_vector = '0;
      assign out_offset = win_any ? OFS_W'(HALF_BASE + int'(win_idx) * HALF_STEP) : '0;
    end else begin : g_vec
      assign out_vector = win_any ? win_idx : '0;
      assign out_offset = '0;
    end
  endgenerate

  assign rel   = ack_offset - OFS_W'(HALF_BASE);
  assign idx_o = VEC_W'(rel >> STEP_SH);
  assign fit_o = (int'(ack_offset) >= HALF_BASE) && (rel[STEP_SH-1:0] == '0) &&
                 ((int'(rel) >> STEP_SH) < (1 << VEC_W));

  assign ack_idx = (OFFSET_MODE != 0) ? idx_o : ack_vector;
  assign ack_ok  = ((OFFSET_MODE == 0) || fit_o) && (int'(ack_idx) < NUM_CH) &&
                   (int'(ack_level) == int'(ack_idx) + 1);
endmodule

// File: rtl/eic_core.sv
module eic_core
  import eic_pkg::*;
#(
  parameter int NUM_CH      = 64,
  parameter int NUM_SENSE   = 32,
  parameter int OFFSET_MODE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] irq_in,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [7:0]        req_level,
  output logic [5:0]        req_vector,
  output logic [17:1]       req_offset,
  output logic              ctrl_present,
  input  logic              ack_pulse,
  input  logic [7:0]        ack_level,
  input  logic [5:0]        ack_vector,
  input  logic [17:1]       ack_offset
);
  localparam int CH_PER_SW = REG_W / 2;
  localparam int SENSE_B   = 2 * NUM_SENSE;

  logic              wr_en, rd_en;
  logic [NUM_CH-1:0] set_vec, clr_sw_vec, ack_clr_vec;
  logic [NUM_CH-1:0] flags_q, edge_vec, evt_vec, mask_q;
  logic [SENSE_B-1:0] sense_q;
  logic              auto_q;
  logic [REG_W-1:0]  rd_word;
  logic              win_any;
  logic [VEC_W-1:0]  win_idx, ack_idx;
  logic              ack_ok;
  logic [LVL_W-1:0]  m_level;
  logic [VEC_W-1:0]  m_vector;
  logic [OFS_W-1:0]  m_offset;

  assign wr_en = reg_valid & reg_write;
  assign rd_en = reg_valid & ~reg_write;
  assign ctrl_present = 1'b1;

  // write-one strobes for set and clear
  always_comb begin
    set_vec    = '0;
    clr_sw_vec = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (wr_en && reg_addr == A_SET + ADDR_W'(i / REG_W)) set_vec[i] = reg_wdata[i % REG_W];
      if (wr_en && reg_addr == A_CLR + ADDR_W'(i / REG_W)) clr_sw_vec[i] = reg_wdata[i % REG_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      auto_q <= 1'b0;
      for (int c = 0; c < NUM_SENSE; c++) sense_q[2*c +: 2] <= SENSE_RISE;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_CH; i++)
        if (reg_addr == A_MASK + ADDR_W'(i / REG_W)) mask_q[i] <= reg_wdata[i % REG_W];
      for (int c = 0; c < NUM_SENSE; c++)
        if (reg_addr == A_SENSE + ADDR_W'(c / CH_PER_SW))
          sense_q[2*c +: 2] <= reg_wdata[2*(c % CH_PER_SW) +: 2];
      if (reg_addr == A_CTRL) auto_q <= reg_wdata[0];
    end
  end

  eic_map #(.NUM_CH(NUM_CH), .OFFSET_MODE(OFFSET_MODE)) u_map (
    .win_any(win_any), .win_idx(win_idx),
    .out_level(m_level), .out_vector(m_vector), .out_offset(m_offset),
    .ack_level(ack_level), .ack_vector(ack_vector), .ack_offset(ack_offset),
    .ack_idx(ack_idx), .ack_ok(ack_ok)
  );

  always_comb begin
    ack_clr_vec = '0;
    for (int i = 0; i < NUM_CH; i++)
      ack_clr_vec[i] = ack_ok && (int'(ack_idx) == i);
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      if (g < NUM_SENSE) begin : g_sense
        eic_channel #(.CONFIGURABLE(1'b1)) u_ch (
          .clk(clk), .rst(rst), .din(irq_in[g]),
          .mode(sense_e'(sense_q[2*g +: 2])),
          .sw_set(set_vec[g]),
          .clr(clr_sw_vec[g] | (ack_pulse & auto_q & ack_clr_vec[g])),
          .flag(flags_q[g]), .is_edge(edge_vec[g]), .evt(evt_vec[g])
        );
      end else begin : g_level
        eic_channel #(.CONFIGURABLE(1'b0)) u_ch (
          .clk(clk), .rst(rst), .din(irq_in[g]),
          .mode(SENSE_RISE),
          .sw_set(set_vec[g]),
          .clr(clr_sw_vec[g] | (ack_pulse & auto_q & ack_clr_vec[g])),
          .flag(flags_q[g]), .is_edge(edge_vec[g]), .evt(evt_vec[g])
        );
      end
    end
  endgenerate

  eic_prio_tree #(.N(NUM_CH), .IW(VEC_W)) u_tree (
    .req(flags_q & mask_q), .any(win_any), .idx(win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_level  <= '0;
      req_vector <= '0;
      req_offset <= '0;
    end else begin
      req_level  <= m_level;
      req_vector <= m_vector;
      req_offset <= m_offset;
    end
  end

  always_comb begin
    rd_word = '0;
    if (reg_addr == A_FLAG || reg_addr == A_FLAG + 4'd1) begin
      for (int i = 0; i < NUM_CH; i++)
        if (i / REG_W == int'(reg_addr - A_FLAG)) rd_word[i % REG_W] = flags_q[i];
    end else if (reg_addr == A_MASK || reg_addr == A_MASK + 4'd1) begin
      for (int i = 0; i < NUM_CH; i++)
        if (i / REG_W == int'(reg_addr - A_MASK)) rd_word[i % REG_W] = mask_q[i];
    end else if (reg_addr == A_SENSE || reg_addr == A_SENSE + 4'd1) begin
      for (int c = 0; c < NUM_SENSE; c++)
        if (c / CH_PER_SW == int'(reg_addr - A_SENSE))
          rd_word[2*(c % CH_PER_SW) +: 2] = sense_q[2*c +: 2];
    end else if (reg_addr == A_CTRL) begin
      rd_word[0] = auto_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        reg_rdata <= '0;
    else if (rd_en) reg_rdata <= rd_word;
  end
endmodule

// File: rtl/eic_core_chk.sv
module eic_core_chk #(
  parameter int NUM_CH      = 64,
  parameter int OFFSET_MODE = 1
) (
  input logic              clk,
  input logic              rst,
  input logic [7:0]        req_level,
  input logic [5:0]        req_vector,
  input logic [17:1]       req_offset,
  input logic [NUM_CH-1:0] flags_q,
  input logic [NUM_CH-1:0] mask_q,
  input logic [NUM_CH-1:0] edge_vec,
  input logic [NUM_CH-1:0] evt_vec,
  input logic [NUM_CH-1:0] set_vec,
  input logic [NUM_CH-1:0] ack_clr_vec,
  input logic              ack_pulse,
  input logic              auto_q,
  input logic              reg_valid,
  input logic              reg_write
);
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (req_level == 8'd0) |-> (req_vector == 6'd0 && req_offset == 17'd0));

  p_code_map_r9: assert property (@(posedge clk) disable iff (rst)
    (req_level != 8'd0) |->
      ((OFFSET_MODE != 0) ?
        (req_offset == 17'(32'h100 + (32'(req_level) - 32'd1) * 32'd16) && req_vector == 6'd0) :
        (req_vector == 6'(req_level - 8'd1) && req_offset == 17'd0)));

  p_pending_r11: assert property (@(posedge clk) disable iff (rst)
    (|(flags_q & mask_q)) |=> (req_level != 8'd0));

  p_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !(|(flags_q & mask_q)) |=> (req_level == 8'd0));

  p_ack_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (ack_pulse && auto_q && !(reg_valid && reg_write)) |=>
      ((flags_q & $past(ack_clr_vec & edge_vec & ~evt_vec & ~set_vec)) == '0));

  p_ack_keep_r10: assert property (@(posedge clk) disable iff (rst)
    (ack_pulse && !auto_q && !(reg_valid && reg_write)) |=>
      (($past(flags_q & edge_vec) & ~flags_q) == '0));
endmodule

bind eic_core eic_core_chk #(.NUM_CH(NUM_CH), .OFFSET_MODE(OFFSET_MODE)) u_chk (
  .clk(clk), .rst(rst),
  .req_level(req_level), .req_vector(req_vector), .req_offset(req_offset),
  .flags_q(flags_q), .mask_q(mask_q), .edge_vec(edge_vec), .evt_vec(evt_vec),
  .set_vec(set_vec), .ack_clr_vec(ack_clr_vec), .ack_pulse(ack_pulse),
  .auto_q(auto_q), .reg_valid(reg_valid), .reg_write(reg_write)
);

// File: tb/tb_eic_core.sv
module tb_eic_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] irq_in = '0;
  logic        reg_valid = 1'b0, reg_write = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        ack_pulse = 1'b0;
  logic [7:0]  ack_level = '0;
  logic [5:0]  ack_vector = '0;
  logic [17:1] ack_offset = '0;

  logic [31:0] rd_o, rd_v;
  logic [7:0]  lvl_o, lvl_v;
  logic [5:0]  vec_o, vec_v;
  logic [17:1] ofs_o, ofs_v;
  logic        pres_o, pres_v;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    int          kind;
    int          ch;
    logic [31:0] rdv;
    string       req;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  eic_core #(.OFFSET_MODE(1)) dut (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rd_o),
    .req_level(lvl_o), .req_vector(vec_o), .req_offset(ofs_o), .ctrl_present(pres_o),
    .ack_pulse(ack_pulse), .ack_level(ack_level), .ack_vector(ack_vector), .ack_offset(ack_offset)
  );

  eic_core #(.OFFSET_MODE(0)) dut_vec (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rd_v),
    .req_level(lvl_v), .req_vector(vec_v), .req_offset(ofs_v), .ctrl_present(pres_v),
    .ack_pulse(ack_pulse), .ack_level(ack_level), .ack_vector(ack_vector), .ack_offset(ack_offset)
  );

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops one expected item per falling edge and compares
  always @(negedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      int ch;
      it = sb.pop_front();
      ch = it.ch;
      if (it.kind == 0) begin
        cmp(it.req, "level(ofs)", 32'(lvl_o), ch < 0 ? 0 : ch + 1);
        cmp(it.req, "offset",     32'(ofs_o), ch < 0 ? 0 : (32'h200 + ch * 32'h20) >> 1);
        cmp(it.req, "vector(ofs)", 32'(vec_o), 0);
        cmp(it.req, "level(vec)", 32'(lvl_v), ch < 0 ? 0 : ch + 1);
        cmp(it.req, "vector",     32'(vec_v), ch < 0 ? 0 : ch);
        cmp(it.req, "offset(vec)", 32'(ofs_v), 0);
        cmp(it.req, "present",    32'(pres_o & pres_v), 1);
      end else begin
        cmp(it.req, "rdata(ofs)", rd_o, it.rdv);
        cmp(it.req, "rdata(vec)", rd_v, it.rdv);
      end
    end
  end

  task automatic expect_ch(int ch, string req);
    item_t it;
    it.kind = 0; it.ch = ch; it.rdv = '0; it.req = req;
    sb.push_back(it);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle_expect(int ch, string req);
    tick(4);
    expect_ch(ch, req);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] exp, string req);
    item_t it;
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_valid = 1'b0;
    it.kind = 1; it.ch = 0; it.rdv = exp; it.req = req;
    sb.push_back(it);
  endtask

  task automatic ack(int ch);
    @(negedge clk);
    ack_pulse = 1'b1; ack_level = 8'(ch + 1); ack_vector = 6'(ch);
    ack_offset = 17'(32'h100 + ch * 16);
    @(negedge clk);
    ack_pulse = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    tick(5);
    rst = 1'b0;
    tick(1);
    expect_ch(-1, "R1 reset outputs");
    rd(4'd0, 32'h0, "R1 flags");
    rd(4'd6, 32'h0, "R1 mask");
    rd(4'd10, 32'h0, "R1 ctrl");
    rd(4'd8, 32'h55555555, "R1 sense lo");
    rd(4'd9, 32'h55555555, "R1 sense hi");

    wr(4'd6, 32'hFFFF_FFFF);
    wr(4'd7, 32'hFFFF_FFFF);
    rd(4'd7, 32'hFFFF_FFFF, "R7 mask readback");

    // R11 latency on a rising edge channel
    @(negedge clk); irq_in[3] = 1'b1;
    tick(3); expect_ch(-1, "R11 before fourth edge");
    tick(1); expect_ch(3, "R11 at fourth edge");
    @(negedge clk); irq_in[3] = 1'b0;
    settle_expect(3, "R3 rising edge held");
    rd(4'd0, 32'h8, "R2 flag bit 3");

    // R7 priority and mask
    @(negedge clk); irq_in[10] = 1'b1;
    settle_expect(10, "R7 higher channel wins");
    wr(4'd6, 32'hFFFF_FBFF);
    settle_expect(3, "R7 masked channel loses");
    wr(4'd6, 32'hFFFF_FFFF);

    // R6 software clear and set
    wr(4'd4, 32'h0000_0408);
    settle_expect(-1, "R6 software clear");
    rd(4'd0, 32'h0, "R6 flags cleared");
    @(negedge clk); irq_in[10] = 1'b0;
    wr(4'd2, 32'h0000_1000);
    settle_expect(12, "R6 software set");
    rd(4'd0, 32'h1000, "R6 flag bit 12");
    wr(4'd4, 32'h0000_1000);
    settle_expect(-1, "R6 clear again");

    // R3 falling edge on ch5, any edge on ch6
    wr(4'd8, 32'h5555_7955);
    rd(4'd8, 32'h5555_7955, "R3 sense readback");
    @(negedge clk); irq_in[5] = 1'b1;
    settle_expect(-1, "R3 falling mode ignores rise");
    @(negedge clk); irq_in[5] = 1'b0;
    settle_expect(5, "R3 falling edge caught");
    wr(4'd4, 32'h20);
    @(negedge clk); irq_in[6] = 1'b1;
    settle_expect(6, "R3 any edge rise");
    wr(4'd4, 32'h40);
    settle_expect(-1, "R3 any edge cleared");
    @(negedge clk); irq_in[6] = 1'b0;
    settle_expect(6, "R3 any edge fall");
    wr(4'd4, 32'h40);

    // R5 low-level channel 7
    wr(4'd8, 32'h5555_3955);
    settle_expect(7, "R5 low level active");
    wr(4'd4, 32'h80);
    settle_expect(7, "R5 clear ignored on level");
    @(negedge clk); irq_in[7] = 1'b1;
    settle_expect(-1, "R5 level released");
    wr(4'd2, 32'h80);
    settle_expect(-1, "R5 set ignored on level");
    rd(4'd0, 32'h0, "R5 flags after set");

    // R4 fixed level-high channel 40
    @(negedge clk); irq_in[40] = 1'b1;
    settle_expect(40, "R4 level high channel");
    wr(4'd5, 32'h100);
    settle_expect(40, "R4 clear ignored");
    @(negedge clk); irq_in[40] = 1'b0;
    settle_expect(-1, "R4 follows input low");

    // R9 highest channel encoding
    @(negedge clk); irq_in[63] = 1'b1;
    settle_expect(63, "R9 channel 63 offset 0x9E0");
    rd(4'd1, 32'h8000_0000, "R2 flag bit 63");
    @(negedge clk); irq_in[63] = 1'b0;
    settle_expect(-1, "R9 channel 63 gone");

    // R10 acknowledge with and without auto-clear
    @(negedge clk); irq_in[20] = 1'b1;
    tick(2);
    @(negedge clk); irq_in[20] = 1'b0;
    settle_expect(20, "R10 edge pending");
    ack(20);
    settle_expect(20, "R10 no clear when disabled");
    wr(4'd10, 32'h1);
    rd(4'd10, 32'h1, "R10 ctrl readback");
    ack(20);
    settle_expect(-1, "R10 auto clear");
    @(negedge clk); irq_in[40] = 1'b1;
    settle_expect(40, "R5 level before ack");
    ack(40);
    settle_expect(40, "R5 ack on active level");
    @(negedge clk); irq_in[40] = 1'b0;
    settle_expect(-1, "R5 level dropped");

    // R7 mask all while pending
    wr(4'd2, 32'h8);
    settle_expect(3, "R7 pending before mask");
    wr(4'd6, 32'h0);
    settle_expect(-1, "R7 all masked");
    rd(4'd0, 32'h8, "R7 flag kept under mask");

    tick(3);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule